// File: doc/BRIEF.md
# Multi-Source Event Queue with Aliased Register Readout

This block collects events from three producers, keypad activity, general-purpose input changes and logic-block outputs, into a sixteen-entry first-in first-out queue. Each entry is one byte: a 7-bit identifier plus a 1-bit state flag. A host reads the queue through a small synchronous register bus. Sixteen consecutive addresses all alias the head of the queue, so a burst read that walks those addresses drains the events oldest first. The number of stored events can be read at its own address.

While a framed host transaction touches any queue address, new events are not written into the queue. Events that arrive in that window wait in a short staging buffer. When the window closes, they enter the queue one per cycle in arrival order. Events that arrive together in one cycle are ordered key first, then general-purpose input, then logic. If an event cannot be stored, it is discarded and a sticky overflow flag is set. The flag can drive an interrupt line when the overflow interrupt enable is high.

Top module: `event_queue`

## Requirements
- R1: After reset, the count reads 0, the status register reads 0x00, irq is low, and a read at any queue address returns 0x00.
- R2: Each stored element keeps the producer's byte unchanged: bit 7 is the event state (1 = press/active) and bits [6:0] are the identifier.
- R3: A read at address 0x02 returns the number of stored events (0 to 16) in bits [4:0], with bits [7:5] zero.
- R4: A read at any address from 0x03 to 0x12 returns the oldest stored event and removes it, so the count falls by one.
- R5: A read at a queue address while the queue is empty returns 0x00 and leaves the count at 0.
- R6: Key events are always recorded. General-purpose input events are recorded only when gpi_en is high, and logic events only when lgc_en is high.
- R7: Events that arrive in the same cycle are queued in the order key, general-purpose input, logic.
- R8: From a read or write at a queue address until bus_act falls, no event enters the queue. Events that arrive in that window are held and then enter the queue in arrival order after bus_act falls.
- R9: When an event arrives while 16 are stored, that event is discarded, the 16 stored entries are kept, the count stays at 16, and bit 2 of address 0x01 becomes 1.
- R10: Writing a byte with bit 2 set to address 0x01 clears the overflow flag. Writing a byte with bit 2 clear leaves the flag unchanged.
- R11: irq is high exactly when the overflow flag is set and ovf_ie is high.
- R12: The staging buffer holds 4 events. An event that finds it full is discarded and sets the overflow flag.
- R13: A read at an address outside 0x01 to 0x12 returns 0x00 and does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | Key event present this cycle |
| key_evt | input | 8 | Key event byte |
| gpi_vld | input | 1 | General-purpose input event present |
| gpi_evt | input | 8 | General-purpose input event byte |
| gpi_en | input | 1 | Enables recording of general-purpose input events |
| lgc_vld | input | 1 | Logic-block event present |
| lgc_evt | input | 8 | Logic-block event byte |
| lgc_en | input | 1 | Enables recording of logic events |
| ovf_ie | input | 1 | Overflow interrupt enable |
| bus_act | input | 1 | Host transaction in progress |
| bus_addr | input | 8 | Host register address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, registered on the read cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
Several properties are checked by assertions on every cycle. The count never goes above the queue or staging depth. A full queue that is offered an event keeps its count and its head. A read on an empty queue leaves the count at zero. A pop lowers the count by exactly one. The count never rises while the hold-off is active. Any discarded event sets the overflow flag. Other behaviours can only be shown by the bench's scenarios, because they depend on ordering across many cycles: same-cycle priority, the source enables, the order in which held events are released, the interplay of alias addresses during a burst drain, and the write-one-to-clear rule together with interrupt gating.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int EVT_W = 8;
  localparam int NSRC  = 3;
  typedef logic [EVT_W-1:0] evt_t;
  localparam logic [7:0] ADDR_STATUS  = 8'h01;
  localparam logic [7:0] ADDR_COUNT   = 8'h02;
  localparam logic [7:0] ADDR_FIFO_LO = 8'h03;
  localparam int         OVF_BIT      = 2;
  localparam logic [7:0] STATUS_MASK  = 8'h04;
endpackage

// File: rtl/evq_stage.sv
// Small staging buffer: accepts up to NSRC events per cycle in lane order
// (lane 0 first), releases one per cycle. DEPTH must be a power of two.
module evq_stage
  import evq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LANES = NSRC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      in_vld,
  input  logic [LANES-1:0][7:0] in_evt,
  input  logic                  pop,
  output logic                  out_vld,
  output evt_t                  out_evt,
  output logic                  drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  evt_t                     mem [DEPTH];
  logic [PW-1:0]            rd_ptr, rd_ptr_nx, wr_ptr, wr_ptr_nx;
  logic [CW-1:0]            cnt, cnt_nx, free, acc;
  logic [LANES-1:0]         wen;
  logic [LANES-1:0][PW-1:0] widx;
  logic                     do_pop;

  assign free    = CW'(DEPTH) - cnt;
  assign out_vld = (cnt != '0);
  assign out_evt = mem[rd_ptr];

  always_comb begin
    acc  = '0;
    drop = 1'b0;
    wen  = '0;
    for (int k = 0; k < LANES; k++) begin
      widx[k] = wr_ptr + acc[PW-1:0];
      if (in_vld[k]) begin
        if (acc < free) begin
          wen[k] = 1'b1;
          acc    = acc + 1'b1;
        end else begin
          drop = 1'b1;
        end
      end
    end
    do_pop    = pop && out_vld;
    wr_ptr_nx = wr_ptr + acc[PW-1:0];
    rd_ptr_nx = do_pop ? rd_ptr + 1'b1 : rd_ptr;
    cnt_nx    = cnt + acc - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr_nx;
      wr_ptr <= wr_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wen[k]) mem[widx[k]] <= in_evt[k];
    end
  end

  // R12
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R12
  stage_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/evq_store.sv
// Main event queue storage with saturating count. DEPTH must be a power of two.
module evq_store
  import evq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  evt_t                         push_evt,
  input  logic                         pop,
  output evt_t                         head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf_drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  evt_t          mem [DEPTH];
  logic [PW-1:0] rd_ptr, rd_ptr_nx, wr_ptr, wr_ptr_nx;
  logic [CW-1:0] cnt_nx;
  logic          full, do_pop, do_push;

  always_comb begin
    full      = (count == CW'(DEPTH));
    do_pop    = pop && (count != '0);
    do_push   = push && (!full || do_pop);
    ovf_drop  = push && !do_push;
    rd_ptr_nx = do_pop  ? rd_ptr + 1'b1 : rd_ptr;
    wr_ptr_nx = do_push ? wr_ptr + 1'b1 : wr_ptr;
    cnt_nx    = count + CW'(do_push) - CW'(do_pop);
    head      = (count != '0) ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nx;
      wr_ptr <= wr_ptr_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_evt;
  end

  // R3
  ec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)) && $stable(head));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (count == '0) && !push) |=> (count == '0));
endmodule

// File: rtl/event_queue.sv
module event_queue
  import evq_pkg::*;
#(
  parameter int QDEPTH    = 16,
  parameter int SDEPTH    = 4,
  parameter int FIFO_SPAN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_vld,
  input  logic [7:0] key_evt,
  input  logic       gpi_vld,
  input  logic [7:0] gpi_evt,
  input  logic       gpi_en,
  input  logic       lgc_vld,
  input  logic [7:0] lgc_evt,
  input  logic       lgc_en,
  input  logic       ovf_ie,
  input  logic       bus_act,
  input  logic [7:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int         QCW      = $clog2(QDEPTH + 1);
  localparam logic [8:0] FIFO_END = 9'(ADDR_FIFO_LO) + 9'(FIFO_SPAN);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic                  fifo_hit, acc_fifo, hold, touched, touched_nx;
  logic [NSRC-1:0]       src_vld;
  logic [NSRC-1:0][7:0]  src_evt;
  logic                  st_vld, st_drop, st_pop;
  evt_t                  st_evt, q_head;
  logic                  q_pop, q_drop;
  logic [QCW-1:0]        ec;
  logic                  ovf, ovf_nx, ovf_clr;
  logic [7:0]            rdata_nx;

  always_comb begin
    fifo_hit   = ({1'b0, bus_addr} >= 9'(ADDR_FIFO_LO)) && ({1'b0, bus_addr} < FIFO_END);
    acc_fifo   = fifo_hit && (bus_rd || bus_wr);
    hold       = acc_fifo || (bus_act && touched);
    touched_nx = bus_act && (touched || acc_fifo);
    // lane 0 has highest priority
    src_vld    = {lgc_vld && lgc_en, gpi_vld && gpi_en, key_vld};
    src_evt    = {lgc_evt, gpi_evt, key_evt};
    st_pop     = st_vld && !hold;
    q_pop      = bus_rd && fifo_hit;
    ovf_clr    = bus_wr && (bus_addr == ADDR_STATUS) && ((bus_wdata & STATUS_MASK) != '0);
    if (st_drop || q_drop) ovf_nx = 1'b1;
    else if (ovf_clr)      ovf_nx = 1'b0;
    else                   ovf_nx = ovf;
    rdata_nx = '0;
    if (fifo_hit)                      rdata_nx = q_head;
    else if (bus_addr == ADDR_COUNT)   rdata_nx = 8'(ec);
    else if (bus_addr == ADDR_STATUS)  rdata_nx[OVF_BIT] = ovf;
  end

  evq_stage #(.DEPTH(SDEPTH), .LANES(NSRC)) stage_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .in_vld  (src_vld),
    .in_evt  (src_evt),
    .pop     (st_pop),
    .out_vld (st_vld),
    .out_evt (st_evt),
    .drop    (st_drop)
  );

  evq_store #(.DEPTH(QDEPTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .push     (st_pop),
    .push_evt (st_evt),
    .pop      (q_pop),
    .head     (q_head),
    .count    (ec),
    .ovf_drop (q_drop)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      touched   <= 1'b0;
      ovf       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      touched <= touched_nx;
      ovf     <= ovf_nx;
      if (bus_rd) bus_rdata <= rdata_nx;
    end
  end

  assign irq = ovf && ovf_ie;

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hold && !q_pop) |=> (ec <= $past(ec)));

  // R4
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q_pop && (ec != '0)) |=> (ec == $past(ec) - 1'b1));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q_drop || st_drop) |=> ovf);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovf && ovf_ie) |-> irq);
endmodule

// File: tb/event_queue_tb.sv
`timescale 1ns/1ps
module event_queue_tb_top;
  logic       clk, rst_n;
  logic       key_vld, gpi_vld, lgc_vld, gpi_en, lgc_en, ovf_ie;
  logic [7:0] key_evt, gpi_evt, lgc_evt;
  logic       bus_act, bus_rd, bus_wr;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       irq;
  int         n_run, n_fail;

  event_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .key_vld(key_vld), .key_evt(key_evt),
    .gpi_vld(gpi_vld), .gpi_evt(gpi_evt), .gpi_en(gpi_en),
    .lgc_vld(lgc_vld), .lgc_evt(lgc_evt), .lgc_en(lgc_en),
    .ovf_ie(ovf_ie), .bus_act(bus_act), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic kv, gv, lv, ge, le;
    logic [7:0] k, g, l;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h83, 8'h00, 8'h00},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h03, 8'h87, 8'h21},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h90, 8'h22},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h91, 8'h23},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 8'h92, 8'h24},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h93, 8'h25}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic inject(input logic kv, input logic [7:0] k, input logic gv,
                        input logic [7:0] g, input logic lv, input logic [7:0] l);
    @(negedge clk);
    key_vld = kv; key_evt = k; gpi_vld = gv; gpi_evt = g; lgc_vld = lv; lgc_evt = l;
    @(negedge clk);
    key_vld = 1'b0; gpi_vld = 1'b0; lgc_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] expq [4];
    int         n;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0;
    key_vld = 0; gpi_vld = 0; lgc_vld = 0; key_evt = 0; gpi_evt = 0; lgc_evt = 0;
    gpi_en = 0; lgc_en = 0; ovf_ie = 0;
    bus_act = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    host_rd(8'h02, d); check("R1 count", d, 8'h00);
    host_rd(8'h01, d); check("R1 status", d, 8'h00);
    host_rd(8'h03, d); check("R1 fifo read", d, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      n = 0;
      if (VEC[v].kv) begin expq[n] = VEC[v].k; n++; end
      if (VEC[v].gv && VEC[v].ge) begin expq[n] = VEC[v].g; n++; end
      if (VEC[v].lv && VEC[v].le) begin expq[n] = VEC[v].l; n++; end
      @(negedge clk);
      gpi_en = VEC[v].ge; lgc_en = VEC[v].le;
      inject(VEC[v].kv, VEC[v].k, VEC[v].gv, VEC[v].g, VEC[v].lv, VEC[v].l);
      idle(4);
      host_rd(8'h02, d); check("R3/R6 count", d, 8'(n));
      bus_act = 1'b1;
      for (int j = 0; j < n; j++) begin
        host_rd(8'(3 + ((j * 5 + v) % 16)), d);
        check("R2/R4/R7 order", d, expq[j]);
      end
      host_rd(8'h12, d); check("R5 empty read", d, 8'h00);
      @(negedge clk); bus_act = 1'b0;
      host_rd(8'h02, d); check("R4/R5 count after drain", d, 8'h00);
    end

    // R8 hold-off during a transaction touching the queue
    gpi_en = 1; lgc_en = 1;
    @(negedge clk); bus_act = 1'b1;
    host_rd(8'h07, d); check("R5 empty alias", d, 8'h00);
    inject(1, 8'h41, 0, 8'h00, 0, 8'h00);
    inject(1, 8'h42, 0, 8'h00, 0, 8'h00);
    inject(0, 8'h00, 1, 8'hC3, 0, 8'h00);
    idle(3);
    host_rd(8'h02, d); check("R8 frozen count", d, 8'h00);
    @(negedge clk); bus_act = 1'b0;
    idle(5);
    host_rd(8'h02, d); check("R8 released count", d, 8'h03);
    bus_act = 1'b1;
    host_rd(8'h0A, d); check("R8 order 1", d, 8'h41);
    host_rd(8'h0B, d); check("R8 order 2", d, 8'h42);
    host_rd(8'h0C, d); check("R8 order 3", d, 8'hC3);
    @(negedge clk); bus_act = 1'b0;

    // R12 staging buffer overflow
    @(negedge clk); bus_act = 1'b1;
    host_rd(8'h12, d);
    inject(1, 8'h51, 1, 8'h52, 1, 8'h53);
    inject(1, 8'h54, 1, 8'h55, 0, 8'h00);
    @(negedge clk); bus_act = 1'b0;
    idle(6);
    host_rd(8'h02, d); check("R12 count", d, 8'h04);
    host_rd(8'h01, d); check("R12 status", d, 8'h04);
    bus_act = 1'b1;
    host_rd(8'h03, d); check("R12 keep 1", d, 8'h51);
    host_rd(8'h04, d); check("R12 keep 2", d, 8'h52);
    host_rd(8'h05, d); check("R12 keep 3", d, 8'h53);
    host_rd(8'h06, d); check("R12 keep 4", d, 8'h54);
    host_rd(8'h07, d); check("R12 dropped", d, 8'h00);
    @(negedge clk); bus_act = 1'b0;
    host_wr(8'h01, 8'h04);
    host_rd(8'h01, d); check("R10 clear", d, 8'h00);

    // R9 queue overflow
    for (int i = 0; i < 17; i++) inject(1, 8'(i), 0, 8'h00, 0, 8'h00);
    idle(4);
    host_rd(8'h02, d); check("R9 count saturates", d, 8'h10);
    host_rd(8'h01, d); check("R9 status", d, 8'h04);
    check("R11 irq masked", {7'b0, irq}, 8'h00);
    @(negedge clk); ovf_ie = 1'b1;
    @(negedge clk); check("R11 irq on", {7'b0, irq}, 8'h01);
    host_rd(8'h13, d); check("R13 outside read", d, 8'h00);
    host_rd(8'h00, d); check("R13 addr 0 read", d, 8'h00);
    host_rd(8'h02, d); check("R13 count kept", d, 8'h10);
    host_wr(8'h01, 8'hFB);
    host_rd(8'h01, d); check("R10 write zero bit", d, 8'h04);
    host_wr(8'h01, 8'h04);
    host_rd(8'h01, d); check("R10 cleared", d, 8'h00);
    @(negedge clk); check("R11 irq off", {7'b0, irq}, 8'h00);
    bus_act = 1'b1;
    for (int i = 0; i < 16; i++) begin
      host_rd(8'(3 + i), d); check("R9 kept entries", d, 8'(i));
    end
    host_rd(8'h03, d); check("R9 new event discarded", d, 8'h00);
    @(negedge clk); bus_act = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule